// File: doc/BRIEF.md
# EDO DRAM Refresh and Start-Up Controller

This block keeps the contents of an EDO DRAM array alive and brings the array into service after reset. Once reset is released it holds every strobe inactive for a long power-up wait. It then runs a fixed number of warm-up refresh cycles on its own, and only after that raises its ready flag. Until ready is high the access engine must not touch the memory.

In service, an interval timer adds one owed refresh every refresh period to a small saturating counter. Whenever a refresh is owed, the block raises a request to the access sequencer. When the grant arrives, it drives a CAS-before-RAS refresh cycle straight onto the strobes: CAS falls first, RAS follows, both return high together, and then a precharge gap is kept. The device's internal row counter supplies the row, so the address bus is left alone. Write-enable is held high at all times, so a refresh can never fall into the device's test entry.

The controller FSM has the states CT_PAUSE (power-up wait), CT_WARM (warm-up refreshes), CT_IDLE (ready, nothing owed), CT_REQ (request raised, waiting for grant) and CT_RUN (granted refresh in progress). Its transitions are:
- CT_PAUSE→CT_WARM when the wait count expires.
- CT_WARM→CT_IDLE when the last warm-up cycle completes.
- CT_IDLE→CT_REQ when the owed count is non-zero.
- CT_REQ→CT_RUN on a sampled grant.
- CT_RUN→CT_IDLE when the strobe cycle completes.

The strobe sequencer FSM has the states SQ_IDLE, SQ_LEAD (CAS low only), SQ_ACTIVE (CAS and RAS low) and SQ_PRECH (both high). Its transitions are:
- SQ_IDLE→SQ_LEAD on start.
- SQ_LEAD→SQ_ACTIVE, SQ_ACTIVE→SQ_PRECH and SQ_PRECH→SQ_IDLE, each when that state's cycle count runs out.

Top module: `dram_rfsh_ctrl`

## Requirements
- R1: While reset (rst_n, active low, synchronous) is asserted, ras_n, cas_n and we_n are 1, and ready and rfsh_req are 0. This also holds when reset arrives in the middle of a refresh cycle.
- R2: After reset is released, no strobe goes low before the power-up wait ends. cas_n first falls after the (PAUSE_CYC+1)-th rising clock edge following release.
- R3: In every refresh cycle, cas_n is low for exactly LEAD_CYC cycles before ras_n falls. ras_n is never low while cas_n is high.
- R4: ras_n stays low for exactly ACT_CYC cycles. ras_n and cas_n return to 1 on the same clock edge, and both then stay high for at least PRE_CYC cycles before cas_n falls again.
- R5: After the wait, exactly WARM_N refresh cycles run without any grant. ready rises only after the last of them completes. rfsh_req is 0 whenever ready is 0.
- R6: In service, a refresh cycle starts only on an edge that samples rfsh_gnt=1 while rfsh_req=1. rfsh_req stays high until granted. A grant while rfsh_req is 0 produces no strobe activity.
- R7: Once ready, one refresh becomes owed every REFI_CYC cycles. The first owed refresh raises rfsh_req on the (REFI_CYC+1)-th edge after ready rises.
- R8: The owed count never exceeds PEND_MAX. If the grant is withheld across more than PEND_MAX intervals, granting afterwards yields exactly PEND_MAX refresh cycles, after which rfsh_req drops.
- R9: we_n is 1 at all times, including when ras_n falls.
- R10: With the grant always available, exactly one refresh cycle is performed per interval, and no interval's refresh is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rfsh_gnt | input | 1 | Grant from the access sequencer |
| rfsh_req | output | 1 | Refresh request; high from request until the granted cycle ends |
| ready | output | 1 | Memory initialised and usable |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The bench builds the block with PAUSE_CYC=50, WARM_N=4, LEAD_CYC=2, ACT_CYC=4, PRE_CYC=3, REFI_CYC=100 and PEND_MAX=3 instead of the 200 µs, 15.6 µs and 8-deep defaults. The short wait and interval let one run cover start-up, four refresh intervals of withheld grant and a steady-service window. The owed-count depth of 3 is small enough that a fourth withheld interval visibly overflows the counter. The short strobe counts keep the exact width checks of the lead, active and precharge phases distinct from one another.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        CT_PAUSE,
        CT_WARM,
        CT_IDLE,
        CT_REQ,
        CT_RUN
    } ctl_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_ACTIVE,
        SQ_PRECH
    } seq_state_t;

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int REFI_CYC = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = $clog2(REFI_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REFI_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/rfsh_pending_ctr.sv
module rfsh_pending_ctr #(
    parameter int PEND_MAX = 8,
    parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] count,
    output logic              nonzero
);
    localparam logic [PEND_W-1:0] TOP = PEND_W'(PEND_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (count != TOP) count <= count + 1'b1;
                2'b01:   if (count != '0)  count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign nonzero = (count != '0);
endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
    import dram_rfsh_pkg::*;
#(
    parameter int LEAD_CYC = 2,
    parameter int ACT_CYC  = 13,
    parameter int PRE_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic idle,
    output logic done,
    output logic ras_n,
    output logic cas_n
);
    localparam int MAX_A = (LEAD_CYC > ACT_CYC) ? LEAD_CYC : ACT_CYC;
    localparam int MAX_C = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] ACT_LD  = CNT_W'(ACT_CYC - 1);
    localparam logic [CNT_W-1:0] PRE_LD  = CNT_W'(PRE_CYC - 1);

    seq_state_t       sq, sq_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            sq  <= sq_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        sq_nxt  = sq;
        cnt_nxt = (cnt == '0) ? cnt : cnt - 1'b1;
        unique case (sq)
            SQ_IDLE: if (start) begin
                sq_nxt  = SQ_LEAD;
                cnt_nxt = LEAD_LD;
            end
            SQ_LEAD: if (cnt == '0) begin
                sq_nxt  = SQ_ACTIVE;
                cnt_nxt = ACT_LD;
            end
            SQ_ACTIVE: if (cnt == '0) begin
                sq_nxt  = SQ_PRECH;
                cnt_nxt = PRE_LD;
            end
            SQ_PRECH: if (cnt == '0) begin
                sq_nxt  = SQ_IDLE;
            end
            default: sq_nxt = SQ_IDLE;
        endcase
    end

    always_comb begin
        idle  = 1'b0;
        done  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        unique case (sq)
            SQ_IDLE:   idle = 1'b1;
            SQ_LEAD:   cas_n = 1'b0;
            SQ_ACTIVE: begin
                cas_n = 1'b0;
                ras_n = 1'b0;
            end
            SQ_PRECH:  done = (cnt == '0);
            default:   idle = 1'b0;
        endcase
    end
endmodule

// File: rtl/dram_rfsh_ctrl.sv
module dram_rfsh_ctrl
    import dram_rfsh_pkg::*;
#(
    parameter int PAUSE_CYC = 50000,
    parameter int WARM_N    = 8,
    parameter int LEAD_CYC  = 2,
    parameter int ACT_CYC   = 13,
    parameter int PRE_CYC   = 8,
    parameter int REFI_CYC  = 3900,
    parameter int PEND_MAX  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_gnt,
    output logic rfsh_req,
    output logic ready,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
    localparam int WARM_W  = $clog2(WARM_N + 1);
    localparam int PEND_W  = $clog2(PEND_MAX + 1);
    localparam logic [PAUSE_W-1:0] PAUSE_LAST = PAUSE_W'(PAUSE_CYC - 1);
    localparam logic [WARM_W-1:0]  WARM_LAST  = WARM_W'(WARM_N - 1);

    ctl_state_t          st, st_nxt;
    logic [PAUSE_W-1:0]  pause_cnt;
    logic [WARM_W-1:0]   warm_cnt;
    logic [PEND_W-1:0]   pend_cnt;
    logic                pend_nz;
    logic                tick;
    logic                seq_start, seq_idle, seq_done;
    logic                pend_dec;

    rfsh_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ready),
        .tick  (tick)
    );

    rfsh_pending_ctr #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tick),
        .dec     (pend_dec),
        .count   (pend_cnt),
        .nonzero (pend_nz)
    );

    rfsh_strobe_seq #(
        .LEAD_CYC (LEAD_CYC),
        .ACT_CYC  (ACT_CYC),
        .PRE_CYC  (PRE_CYC)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (seq_start),
        .idle  (seq_idle),
        .done  (seq_done),
        .ras_n (ras_n),
        .cas_n (cas_n)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CT_PAUSE;
        else        st <= st_nxt;
    end

    // start-up counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_cnt <= '0;
            warm_cnt  <= '0;
        end else begin
            if (st == CT_PAUSE)             pause_cnt <= pause_cnt + 1'b1;
            if (st == CT_WARM && seq_done)  warm_cnt  <= warm_cnt + 1'b1;
        end
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            CT_PAUSE: if (pause_cnt == PAUSE_LAST)          st_nxt = CT_WARM;
            CT_WARM:  if (seq_done && warm_cnt == WARM_LAST) st_nxt = CT_IDLE;
            CT_IDLE:  if (pend_nz)                          st_nxt = CT_REQ;
            CT_REQ:   if (rfsh_gnt)                         st_nxt = CT_RUN;
            CT_RUN:   if (seq_done)                         st_nxt = CT_IDLE;
            default:                                        st_nxt = CT_PAUSE;
        endcase
    end

    // outputs
    always_comb begin
        seq_start = 1'b0;
        rfsh_req  = 1'b0;
        ready     = 1'b0;
        pend_dec  = 1'b0;
        unique case (st)
            CT_PAUSE: ready = 1'b0;
            CT_WARM:  seq_start = seq_idle;
            CT_IDLE:  ready = 1'b1;
            CT_REQ: begin
                ready     = 1'b1;
                rfsh_req  = 1'b1;
                seq_start = rfsh_gnt;
            end
            CT_RUN: begin
                ready    = 1'b1;
                rfsh_req = 1'b1;
                pend_dec = seq_done;
            end
            default: ready = 1'b0;
        endcase
    end

    assign we_n = 1'b1;
endmodule

// File: rtl/dram_rfsh_checker.sv
module dram_rfsh_checker #(
    parameter int PEND_MAX = 8,
    parameter int PEND_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              ready,
    input logic              rfsh_req,
    input logic              rfsh_gnt,
    input logic [PEND_W-1:0] pend_cnt
);
    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));                     // R3

    AST_RAS_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);                                              // R3

    AST_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> $rose(cas_n));                                  // R4

    AST_NO_REQ_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_req |-> ready);                                             // R5

    AST_START_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && ready) |-> ($past(rfsh_gnt) && $past(rfsh_req))); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= PEND_W'(PEND_MAX));                                  // R8
endmodule

bind dram_rfsh_ctrl dram_rfsh_checker #(
    .PEND_MAX (PEND_MAX),
    .PEND_W   (PEND_W)
) u_rfsh_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ready    (ready),
    .rfsh_req (rfsh_req),
    .rfsh_gnt (rfsh_gnt),
    .pend_cnt (pend_cnt)
);

// File: tb/dram_rfsh_ctrl_bench.sv
`timescale 1ns/1ps
module dram_rfsh_ctrl_bench;
    localparam int P_PAUSE = 50;
    localparam int P_WARM  = 4;
    localparam int P_LEAD  = 2;
    localparam int P_ACT   = 4;
    localparam int P_PRE   = 3;
    localparam int P_REFI  = 100;
    localparam int P_PEND  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rfsh_gnt = 1'b0;
    logic rfsh_req, ready, ras_n, cas_n, we_n;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dram_rfsh_ctrl #(
        .PAUSE_CYC (P_PAUSE),
        .WARM_N    (P_WARM),
        .LEAD_CYC  (P_LEAD),
        .ACT_CYC   (P_ACT),
        .PRE_CYC   (P_PRE),
        .REFI_CYC  (P_REFI),
        .PEND_MAX  (P_PEND)
    ) u_dram_rfsh_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rfsh_gnt (rfsh_gnt),
        .rfsh_req (rfsh_req),
        .ready    (ready),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n)
    );

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // strobe shape monitor
    logic p_cas = 1'b1, p_ras = 1'b1, p_gnt = 1'b0, p_req = 1'b0;
    int cas_run = 0, ras_run = 0, high_run = P_PRE, rf_cnt = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_cas = 1'b1; p_ras = 1'b1; p_gnt = 1'b0; p_req = 1'b0;
            cas_run = 0; ras_run = 0; high_run = P_PRE; rf_cnt = 0;
        end else begin
            if (p_cas && !cas_n) begin
                check("R4 precharge gap", high_run >= P_PRE, high_run, P_PRE);
                if (ready) check("R6 start only after grant", p_gnt && p_req, int'(p_gnt && p_req), 1);
            end
            if (p_ras && !ras_n) begin
                check("R3 CAS lead", cas_run == P_LEAD, cas_run, P_LEAD);
                check("R9 we_n high at RAS fall", we_n == 1'b1, int'(we_n), 1);
            end
            if (!ras_n) check("R3 RAS low needs CAS low", !cas_n, int'(cas_n), 0);
            if (!p_ras && ras_n) begin
                check("R4 RAS active width", ras_run == P_ACT, ras_run, P_ACT);
                check("R4 CAS rises with RAS", cas_n && !p_cas, int'(cas_n), 1);
                rf_cnt++;
            end
            cas_run  = (!cas_n && ras_n) ? cas_run + 1 : (cas_n ? 0 : cas_run);
            ras_run  = !ras_n ? ras_run + 1 : 0;
            high_run = (cas_n && ras_n) ? high_run + 1 : 0;
            p_cas = cas_n; p_ras = ras_n; p_gnt = rfsh_gnt; p_req = rfsh_req;
        end
    end

    task automatic t_reset_state();
        @(posedge clk); #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ras_n in reset", ras_n == 1'b1, int'(ras_n), 1);
        check("R1 cas_n in reset", cas_n == 1'b1, int'(cas_n), 1);
        check("R1 we_n in reset", we_n == 1'b1, int'(we_n), 1);
        check("R1 ready in reset", ready == 1'b0, int'(ready), 0);
        check("R1 rfsh_req in reset", rfsh_req == 1'b0, int'(rfsh_req), 0);
    endtask

    task automatic t_pause();
        int n = 0;
        bit bad = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        for (int i = 0; i < P_PAUSE + 20; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (ready || rfsh_req || !ras_n) bad = 1'b1;
            if (!cas_n) break;
        end
        check("R2 first CAS fall edge", n == P_PAUSE + 1, n, P_PAUSE + 1);
        check("R5 no ready or request in pause", !bad, int'(bad), 0);
    endtask

    task automatic t_warmup();
        bit bad = 1'b0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (rfsh_req) bad = 1'b1;
            if (ready) break;
        end
        check("R5 ready rises", ready == 1'b1, int'(ready), 1);
        check("R5 warm-up count", rf_cnt == P_WARM, rf_cnt, P_WARM);
        check("R5 no request during warm-up", !bad, int'(bad), 0);
    endtask

    task automatic t_interval();
        int n = 0;
        bit act = 1'b0;
        for (int i = 0; i < 3 * P_REFI; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (!cas_n) act = 1'b1;
            if (rfsh_req) break;
        end
        check("R7 first request after interval", n == P_REFI + 1, n, P_REFI + 1);
        check("R6 no strobe before grant", !act, int'(act), 0);
    endtask

    task automatic t_saturate();
        int start;
        bit act = 1'b0;
        bit dropped = 1'b0;
        for (int i = 0; i < 340; i++) begin
            @(negedge clk);
            if (!cas_n) act = 1'b1;
            if (!rfsh_req) dropped = 1'b1;
        end
        check("R6 request held without grant", !dropped, int'(dropped), 0);
        check("R6 no strobe while ungranted", !act, int'(act), 0);
        start = rf_cnt;
        @(posedge clk); #1 rfsh_gnt = 1'b1;
        repeat (45) @(negedge clk);
        check("R8 served after overflow", rf_cnt - start == P_PEND, rf_cnt - start, P_PEND);
        check("R8 request drops when drained", rfsh_req == 1'b0, int'(rfsh_req), 0);
    endtask

    task automatic t_gnt_ignored();
        bit act = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!cas_n || !ras_n || rfsh_req) act = 1'b1;
        end
        check("R6 grant without request ignored", !act, int'(act), 0);
    endtask

    task automatic t_steady();
        int start;
        for (int i = 0; i < 3 * P_REFI; i++) begin
            @(negedge clk);
            if (rfsh_req) break;
        end
        start = rf_cnt;
        repeat (5 * P_REFI - 20) @(negedge clk);
        check("R10 one refresh per interval", rf_cnt - start == 5, rf_cnt - start, 5);
    endtask

    task automatic t_reset_mid();
        for (int i = 0; i < 3 * P_REFI; i++) begin
            @(negedge clk);
            if (!ras_n) break;
        end
        check("R1 reached active phase", ras_n == 1'b0, int'(ras_n), 0);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 strobes idle after mid-cycle reset", ras_n && cas_n, int'(ras_n && cas_n), 1);
        check("R1 ready and request low after reset", !ready && !rfsh_req, int'(ready || rfsh_req), 0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_pause();
        t_warmup();
        t_interval();
        t_saturate();
        t_gnt_ignored();
        t_steady();
        t_reset_mid();
        t_pause();
        t_warmup();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end
endmodule